// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block holds the digital code for an 8-bit converter in two register stages controlled by a processor-style write interface. The first stage, the staging register, takes the data bus while chip select and the first write strobe are low and the latch enable is high. The second stage, the output register, takes the staging register's contents while the second write strobe and the transfer strobe are both low. The output register drives the code output and its bitwise complement.

Every control is level-sensitive and sampled on each clock edge. A stage that is enabled on an edge loads on that edge. Tying controls to fixed levels gives three operating styles: flow-through, where both stages follow the bus; single-buffered, where one strobe updates the output directly; and double-buffered, where many converters are preloaded and then updated together by a shared transfer strobe. When both stages are enabled on the same edge, the output register loads the data the staging register is loading on that edge, so the path adds no extra cycle.

Top module: `dbuf_dac_code`

## Requirements
- R1: When reset is asserted, both stages clear to 0x00. Afterwards, a transfer with the first stage blocked gives code 0x00.
- R2: On a clock edge, the staging register loads data_in only when cs_n=0, wr1_n=0 and ile=1. It holds its value when cs_n=1, wr1_n=1 or ile=0.
- R3: On a clock edge, the output register loads only when wr2_n=0 and xfer_n=0. While either of these is 1, code_out does not change, whatever the staging register does.
- R4: Flow-through: with cs_n, wr1_n, wr2_n and xfer_n at 0 and ile at 1, code_out after each edge equals the data_in sampled at that edge.
- R5: Single-buffered: with cs_n, wr2_n and xfer_n at 0 and ile at 1, an edge on which wr1_n is 0 sets code_out to data_in on that same edge.
- R6: Double-buffered: a value loaded into the staging register while xfer_n=1 appears on code_out only after an edge with wr2_n=0 and xfer_n=0.
- R7: When the write strobe stays qualified over several edges while data changes, the value kept is the data sampled at the last edge before the strobe is released.
- R8: code_inv always equals the bitwise inverse of code_out.
- R9: data_in bit i (bit 0 the least significant, bit 7 the most significant) reaches code_out bit i.
- R10: Reset assertion is asynchronous: code_out reads 0x00 before the next clock edge. Release is synchronized, and the stages resume loading on the third rising edge after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| data_in | input | 8 | Code bus, bit 0 least significant |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Staging write strobe, active low |
| ile | input | 1 | Staging latch enable, active high |
| wr2_n | input | 1 | Output write strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| code_out | output | 8 | Output register contents |
| code_inv | output | 8 | Bitwise complement of code_out |

## Verification
The staging load and the output transfer can fall on the same clock edge. The bench provokes this in flow-through and single-buffered configurations and judges it by requiring code_out, one edge later, to equal the data on the bus at that edge rather than the older staging value. The opposite case, a staging load while a transfer is blocked, is judged by checking that code_out stays unchanged until a separate transfer edge moves the staged value out.

// File: rtl/dbuf_dac_pkg.sv
package dbuf_dac_pkg;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned RST_STAGES_DEF = 2;

  typedef struct packed {
    logic cs_n;
    logic wr1_n;
    logic ile;
  } stage1_ctl_t;

  typedef struct packed {
    logic wr2_n;
    logic xfer_n;
  } stage2_ctl_t;

  function automatic logic stage1_open(stage1_ctl_t c);
    return (!c.cs_n) && (!c.wr1_n) && c.ile;
  endfunction

  function automatic logic stage2_open(stage2_ctl_t c);
    return (!c.wr2_n) && (!c.xfer_n);
  endfunction
endpackage

// File: rtl/dbuf_rst_sync.sv
module dbuf_rst_sync #(
  parameter int unsigned STAGES = dbuf_dac_pkg::RST_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      assign chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dbuf_stage_in.sv
module dbuf_stage_in
  import dbuf_dac_pkg::*;
#(
  parameter int unsigned W = CODE_W_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  stage1_ctl_t ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic load_en;

  always_comb begin
    load_en = stage1_open(ctl);
    q_next  = load_en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/dbuf_stage_out.sv
module dbuf_stage_out
  import dbuf_dac_pkg::*;
#(
  parameter int unsigned W = CODE_W_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  stage2_ctl_t ctl,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  logic         xfer_en;
  logic [W-1:0] q_d;

  always_comb begin
    xfer_en = stage2_open(ctl);
    q_d     = xfer_en ? src : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (xfer_en) q <= q_d;
  end
endmodule

// File: rtl/dbuf_dac_code.sv
module dbuf_dac_code
  import dbuf_dac_pkg::*;
#(
  parameter int unsigned CODE_W     = CODE_W_DEF,
  parameter int unsigned RST_STAGES = RST_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] data_in,
  input  logic              cs_n,
  input  logic              wr1_n,
  input  logic              ile,
  input  logic              wr2_n,
  input  logic              xfer_n,
  output logic [CODE_W-1:0] code_out,
  output logic [CODE_W-1:0] code_inv
);
  logic              rst_int_n;
  stage1_ctl_t       s1_ctl;
  stage2_ctl_t       s2_ctl;
  logic [CODE_W-1:0] in_q;
  logic [CODE_W-1:0] in_next;
  logic [CODE_W-1:0] out_q;

  assign s1_ctl = '{cs_n: cs_n, wr1_n: wr1_n, ile: ile};
  assign s2_ctl = '{wr2_n: wr2_n, xfer_n: xfer_n};

  dbuf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dbuf_stage_in #(.W(CODE_W)) u_stage_in (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ctl    (s1_ctl),
    .d      (data_in),
    .q      (in_q),
    .q_next (in_next)
  );

  // Output stage takes the staging stage's next value so a same-edge
  // load and transfer costs no extra cycle.
  dbuf_stage_out #(.W(CODE_W)) u_stage_out (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ctl   (s2_ctl),
    .src   (in_next),
    .q     (out_q)
  );

  assign code_out = out_q;

  generate
    for (genvar i = 0; i < CODE_W; i++) begin : g_inv
      assign code_inv[i] = ~out_q[i];
    end
  endgenerate
endmodule

// File: rtl/dbuf_dac_code_chk.sv
module dbuf_dac_code_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [CODE_W-1:0] data_in,
  input logic              cs_n,
  input logic              wr1_n,
  input logic              ile,
  input logic              wr2_n,
  input logic              xfer_n,
  input logic [CODE_W-1:0] in_q,
  input logic [CODE_W-1:0] code_out,
  input logic [CODE_W-1:0] code_inv
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_int_n |-> (code_out == '0 && in_q == '0));

  p_stage_load_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cs_n && !wr1_n && ile) |=> (in_q == $past(data_in)));

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n || wr1_n || !ile) |=> $stable(in_q));

  p_out_blocked_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr2_n || xfer_n) |=> $stable(code_out));

  p_out_takes_stage_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr2_n && !xfer_n && (cs_n || wr1_n || !ile)) |=> (code_out == $past(in_q)));

  p_flow_through_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cs_n && !wr1_n && ile && !wr2_n && !xfer_n) |=> (code_out == $past(data_in)));

  p_complement_r8: assert property (@(posedge clk)
    code_inv == ~code_out);
endmodule

bind dbuf_dac_code dbuf_dac_code_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .data_in   (data_in),
  .cs_n      (cs_n),
  .wr1_n     (wr1_n),
  .ile       (ile),
  .wr2_n     (wr2_n),
  .xfer_n    (xfer_n),
  .in_q      (in_q),
  .code_out  (code_out),
  .code_inv  (code_inv)
);

// File: tb/dbuf_dac_code_bench.sv
`timescale 1ns/1ps
module dbuf_dac_code_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] data_in;
  logic       cs_n, wr1_n, ile, wr2_n, xfer_n;
  logic [7:0] code_out, code_inv;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  dbuf_dac_code u_dbuf_dac_code (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .cs_n(cs_n), .wr1_n(wr1_n), .ile(ile), .wr2_n(wr2_n), .xfer_n(xfer_n),
    .code_out(code_out), .code_inv(code_inv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, return 1 ns after the following rising edge.
  task automatic step(logic [7:0] d, logic cs, logic w1, logic le, logic w2, logic xf);
    @(negedge clk);
    data_in = d; cs_n = cs; wr1_n = w1; ile = le; wr2_n = w2; xfer_n = xf;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(logic [7:0] d);
    step(d, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle(8'h00);
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 code after reset", code_out, 8'h00);
    check("R8 inverse after reset", code_inv, 8'hFF);
    step(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // transfer with staging blocked
    check("R1 staging cleared", code_out, 8'h00);
  endtask

  task automatic t_stage_gating_r2();
    step(8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1); // load 0x11
    step(8'h22, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1); // cs_n high
    step(8'h33, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // wr1_n high
    step(8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); // ile low
    check("R3 output held while blocked", code_out, 8'h00);
    step(8'hEE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // transfer
    check("R2 only qualified write kept", code_out, 8'h11);
  endtask

  task automatic t_transfer_block_r3();
    step(8'h77, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // wr2_n high
    check("R3 wr2_n high holds output", code_out, 8'h11);
    step(8'h78, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // xfer_n high
    check("R3 xfer_n high holds output", code_out, 8'h11);
    step(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 transfer moves staged", code_out, 8'h78);
  endtask

  task automatic t_flow_r4();
    logic [7:0] v;
    for (int i = 0; i < 6; i++) begin
      v = 8'(i * 37 + 5);
      step(v, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R4 flow-through follows bus", code_out, v);
      check("R8 inverse in flow-through", code_inv, ~v);
    end
  endtask

  task automatic t_single_r5();
    step(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 strobe updates output same edge", code_out, 8'hC3);
    step(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R5 no strobe keeps output", code_out, 8'hC3);
  endtask

  task automatic t_double_r6();
    step(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 preload leaves output", code_out, 8'hC3);
    idle(8'h00);
    check("R6 still unchanged", code_out, 8'hC3);
    step(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 transfer shows preload", code_out, 8'hA5);
  endtask

  task automatic t_last_edge_r7();
    step(8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step(8'h02, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step(8'h9D, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step(8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // strobe released, data moves
    step(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 last sampled data kept", code_out, 8'h9D);
  endtask

  task automatic t_bits_r9();
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R9 walking one bit position", code_out, 8'(1 << i));
    end
  endtask

  task automatic t_async_r10();
    step(8'h6B, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R10 async clear before edge", code_out, 8'h00);
    @(negedge clk);
    data_in = 8'h4E; cs_n = 1'b0; wr1_n = 1'b0; ile = 1'b1; wr2_n = 1'b0; xfer_n = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 held on first edge", code_out, 8'h00);
    @(posedge clk); #1;
    check("R10 held on second edge", code_out, 8'h00);
    @(posedge clk); #1;
    check("R10 loads on third edge", code_out, 8'h4E);
  endtask

  initial begin
    rst_n = 1'b0; data_in = 8'h00;
    cs_n = 1'b1; wr1_n = 1'b1; ile = 1'b0; wr2_n = 1'b1; xfer_n = 1'b1;
    t_reset_r1();
    t_stage_gating_r2();
    t_transfer_block_r3();
    t_flow_r4();
    t_single_r5();
    t_double_r6();
    t_last_edge_r7();
    t_bits_r9();
    t_async_r10();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule